// File: doc/BRIEF.md
# Strided Pixel Address Generator

This block produces the read addresses that one display overlay channel needs to fetch a frame of pixels. When started, it latches a base address, a pixel size, a frame shape (pixels per line, lines per frame) and two signed stride values. It then presents one pixel address at a time on a valid/accept handshake. A downstream fetch unit takes each address when it is ready. The generator does not issue bus transactions, form bursts or cache data.

Each accepted pixel moves the address forward by one pixel size plus a signed pixel stride. At the last pixel of a line, the address moves to where the next pixel would sit, and the signed line stride is then added on top of that. Both strides count in units of the pixel size. This lets the fetch skip pixels, skip or repeat lines, or walk backwards through memory, and the byte lanes below the pixel size are never disturbed. The output also flags the last pixel of each line and the last pixel of the frame. After the frame's final address is accepted, the block goes idle until the next start.

Top module: `strided_pixel_addr_gen`

## Requirements
- R1: After reset `valid`, `eol` and `eof` are low and stay low until a start is accepted.
- R2: When idle, a `start` pulse with non-zero `line_len` and `line_count` makes `valid` high on the next cycle, with `addr` equal to `base_addr`.
- R3: While `valid` is high and `accept` is low, `addr`, `eol` and `eof` hold their values and `valid` stays high.
- R4: The pixel size code selects bytes per pixel: 0 means 1 byte, 1 means 2 bytes, 2 or 3 mean 4 bytes. Within a line, each accepted address is followed by the previous address plus size × (1 + pixel stride).
- R5: A pixel stride of zero yields contiguous addresses that differ by exactly the pixel size.
- R6: `eol` is high exactly while the address of the last pixel of a line (pixel index `line_len`−1) is presented. Once it is accepted on a line that is not the last, the next address is the previous address plus size × (1 + pixel stride) + size × line stride.
- R7: `eof` is high only together with `eol`, on the last line (index `line_count`−1). After that address is accepted, `valid` goes low and stays low until a new start.
- R8: Both strides are two's complement values, sign-extended before scaling. All address arithmetic wraps modulo 2^AW without saturating.
- R9: A `start` received while a frame is in progress has no effect on the address sequence. A `start` with `line_len` or `line_count` equal to zero leaves the block idle.
- R10: Address bits below the pixel size never change between consecutive addresses of one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (sampled while idle) |
| base_addr | input | AW | First pixel address |
| pix_size | input | 2 | Bytes-per-pixel code |
| line_len | input | CW | Pixels per line |
| line_count | input | CW | Lines per frame |
| pix_stride | input | SW | Signed extra step per pixel, in pixel units |
| line_stride | input | SW | Signed extra step per line, in pixel units |
| accept | input | 1 | Consumer takes the presented address |
| addr | output | AW | Current pixel address |
| valid | output | 1 | Address is presented |
| eol | output | 1 | Presented address is last of its line |
| eof | output | 1 | Presented address is last of the frame |

## Verification
Several properties are checked on every cycle: the address is held during a stall, `eof` only ever appears together with `eol`, the block is idle after the final accept, a zero-sized start is refused, and the sub-pixel address bits stay fixed. The actual address values depend on the strides, the pixel size and where each line ends, so only the bench scenarios can show them. Those scenarios compare every accepted address against an independently computed sequence. They cover negative strides, wrap-around past the top of the address space, a restart attempted mid-frame, and irregular stall patterns.

// File: rtl/strided_pixel_addr_gen.sv
module strided_pixel_addr_gen #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [1:0]    pix_size,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] line_count,
  input  logic [SW-1:0] pix_stride,
  input  logic [SW-1:0] line_stride,
  input  logic          accept,
  output logic [AW-1:0] addr,
  output logic          valid,
  output logic          eol,
  output logic          eof
);
  localparam int EXT = AW - SW;

  logic [1:0]    sh_d, sh_q;
  logic [AW-1:0] ps_ext, ls_ext, step_d, lstep_d;
  logic [AW-1:0] addr_q, step_q, lstep_q;
  logic [CW-1:0] len_q, cnt_q, x_q, y_q;
  logic          valid_q, last_px, last_ln, fire, go;

  assign sh_d    = (pix_size == 2'd0) ? 2'd0 : (pix_size == 2'd1) ? 2'd1 : 2'd2;
  assign ps_ext  = {{EXT{pix_stride[SW-1]}}, pix_stride};
  assign ls_ext  = {{EXT{line_stride[SW-1]}}, line_stride};
  assign step_d  = (AW'(1) << sh_d) + (ps_ext << sh_d);
  assign lstep_d = ls_ext << sh_d;

  assign last_px = (x_q == len_q - CW'(1));
  assign last_ln = (y_q == cnt_q - CW'(1));
  assign fire    = valid_q && accept;
  assign go      = !valid_q && start && (line_len != '0) && (line_count != '0);

  assign addr  = addr_q;
  assign valid = valid_q;
  assign eol   = valid_q && last_px;
  assign eof   = valid_q && last_px && last_ln;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      step_q  <= '0;
      lstep_q <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      sh_q    <= '0;
    end else if (go) begin
      valid_q <= 1'b1;
      addr_q  <= base_addr;
      step_q  <= step_d;
      lstep_q <= lstep_d;
      len_q   <= line_len;
      cnt_q   <= line_count;
      sh_q    <= sh_d;
      x_q     <= '0;
      y_q     <= '0;
    end else if (fire) begin
      if (last_px && last_ln) begin
        valid_q <= 1'b0;
      end else if (last_px) begin
        addr_q <= addr_q + step_q + lstep_q;
        x_q    <= '0;
        y_q    <= y_q + CW'(1);
      end else begin
        addr_q <= addr_q + step_q;
        x_q    <= x_q + CW'(1);
      end
    end
  end

  logic [AW-1:0] lo_mask;
  assign lo_mask = (AW'(1) << sh_q) - AW'(1);

  assert_idle_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !valid && !eol && !eof);

  assert_start_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> valid && addr == $past(base_addr));

  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !accept |=> valid && $stable(addr) && $stable(eol) && $stable(eof));

  assert_eof_with_eol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> eol);

  assert_idle_after_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eof && accept |=> !valid);

  assert_zero_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && start && (line_len == '0 || line_count == '0) |=> !valid);

  assert_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && accept && !eof |=> ((addr ^ $past(addr)) & lo_mask) == '0);
endmodule

// File: tb/strided_pixel_addr_gen_tb.sv
module strided_pixel_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [1:0]  pix_size = '0;
  logic [15:0] line_len = '0, line_count = '0;
  logic [15:0] pix_stride = '0, line_stride = '0;
  logic        accept = 1'b0;
  logic [31:0] addr;
  logic        valid, eol, eof;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  strided_pixel_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .pix_size(pix_size), .line_len(line_len), .line_count(line_count),
    .pix_stride(pix_stride), .line_stride(line_stride), .accept(accept),
    .addr(addr), .valid(valid), .eol(eol), .eof(eof)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Run one frame; stall_mod>0 drops accept every stall_mod-th cycle.
  // restart=1 pulses start with a different base mid-frame (R9).
  task automatic run_frame(input string tag, input logic [31:0] base, input logic [1:0] sz,
                           input int len, input int cnt, input int ps, input int ls,
                           input int stall_mod, input bit restart);
    int sh;
    logic [31:0] exp, step, lstep;
    int cyc;
    sh    = (sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2;
    step  = (32'(1) << sh) + (32'(ps) << sh);
    lstep = 32'(ls) << sh;
    @(negedge clk);
    base_addr = base; pix_size = sz; line_len = 16'(len); line_count = 16'(cnt);
    pix_stride = 16'(ps); line_stride = 16'(ls); start = 1'b1; accept = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 valid"}, 32'(valid), 32'd1);
    chk({tag, " R2 base"}, addr, base);
    exp = base;
    cyc = 0;
    for (int y = 0; y < cnt; y++) begin
      for (int x = 0; x < len; x++) begin
        if (stall_mod > 0 && (cyc % stall_mod) == 1) begin
          accept = 1'b0;
          @(negedge clk);
          chk({tag, " R3 hold"}, addr, exp);
          chk({tag, " R3 valid"}, 32'(valid), 32'd1);
        end
        cyc++;
        chk({tag, " R4 R8 addr"}, addr, exp);
        chk({tag, " R6 eol"}, 32'(eol), 32'(x == len - 1));
        chk({tag, " R7 eof"}, 32'(eof), 32'(x == len - 1 && y == cnt - 1));
        if (restart && y == 0 && x == 0) begin
          base_addr = base ^ 32'h0001_0000;
          start = 1'b1;
        end
        accept = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_addr = base;
        exp = (x == len - 1) ? exp + step + lstep : exp + step;
      end
    end
    accept = 1'b0;
    chk({tag, " R7 idle"}, 32'(valid), 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " R7 stays idle"}, 32'(valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(valid), 32'd0);
    chk("R1 eol", 32'(eol), 32'd0);
    chk("R1 eof", 32'(eof), 32'd0);
  endtask

  task automatic t_zero_shape;
    @(negedge clk);
    base_addr = 32'h100; pix_size = 2'd0; line_len = 16'd0; line_count = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 zero len", 32'(valid), 32'd0);
    line_len = 16'd3; line_count = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 zero count", 32'(valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_frame("contig8", 32'h1000, 2'd0, 5, 1, 0, 0, 0, 1'b0);       // R5
    run_frame("contig16", 32'h2000, 2'd1, 4, 2, 0, 0, 0, 1'b0);      // R5, R6
    run_frame("skip32", 32'h3000, 2'd2, 3, 3, 2, 5, 3, 1'b0);        // R4, R6, R3
    run_frame("code3", 32'h4000, 2'd3, 3, 2, 1, 0, 0, 1'b0);         // R4
    run_frame("backward", 32'h8000, 2'd1, 4, 3, -2, -3, 2, 1'b0);    // R8
    run_frame("wrap", 32'hFFFF_FFFC, 2'd2, 3, 2, 0, 1, 0, 1'b0);     // R8
    run_frame("restart", 32'h5000, 2'd0, 3, 2, 0, 2, 0, 1'b1);       // R9
    run_frame("single", 32'h6002, 2'd1, 1, 1, 0, 0, 0, 1'b0);        // R7
    t_zero_shape();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule